// File: doc/BRIEF.md
# PCM Serial Time-Slot Port

This block connects one telephony codec channel to a time-division highway. The bit clock, the transmit frame sync, the receive frame sync and the serial input are all asynchronous to a faster system clock. The block samples them in that clock and detects their edges there. On the transmit side it sends an 8-bit code, sign bit first, during its own slot. It drives a 3-state data output, made up of a data bit and an enable, and an active-low strobe that marks the slot. On the receive side it collects eight serial bits and hands the assembled word to the decoder with a one-cycle valid pulse.

The width of each transmit sync pulse selects the framing mode for both directions. In long-frame mode the slot opens at the sync edge, and the output can stay on for as long as the sync stays high. In short-frame mode the slot opens one bit period after the sync is seen. A power-down input holds the block idle. After power-up the output stays off until the second transmit sync arrives. The system clock must run at least four times faster than the bit clock.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset or power-down is active, the data enable is low and the strobe is high. Power-down also returns the framing mode to short.
- R2: After power-down is released, the slot started by the first transmit sync does not drive the output. The slot of every later transmit sync does drive it.
- R3: A transmit sync that is high at 3 or more bit-clock falling edges sets long-frame mode. A transmit sync that is high at 1 or 2 such edges sets short-frame mode. The new mode takes effect when that sync falls and applies from the next frame, to both directions.
- R4: Short-frame transmit works as follows. The transmit sync is seen high at a bit-clock falling edge. The next bit-clock rising edge enables the output with bit 7. The next seven rising edges shift out bits 6 down to 0. The falling edge after the last bit disables the output.
- R5: Long-frame transmit works as follows. The output turns on with bit 7 at the transmit sync rise if the bit clock is high, and otherwise at the next bit-clock rising edge. The next seven rising edges send bits 6 down to 0. The output turns off at the later of two events: the bit-clock falling edge after the last bit, or the sync going low. Until then bit 0 is held.
- R6: Each accepted transmit sync loads the present parallel code into a holding buffer. The slot sends the code that the previous sync loaded.
- R7: The strobe is low exactly while the data enable is high.
- R8: Short-frame receive works as follows. The receive sync is seen high at a bit-clock falling edge. The next eight falling edges sample the serial input.
- R9: Long-frame receive works as follows. After a receive sync rise, the next eight bit-clock falling edges sample the serial input.
- R10: The first received bit becomes bit 7 of the word. The word changes only together with a valid pulse, which lasts one clock cycle and follows the eighth sampling edge.
- R11: A transmit sync that rises while a transmit slot is in progress is ignored. It does not restart the slot and it does not load the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down request, active high |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fs_tx_i | input | 1 | Transmit frame sync (asynchronous) |
| fs_rx_i | input | 1 | Receive frame sync (asynchronous) |
| dr_i | input | 1 | Serial receive data |
| tx_code_i | input | SlotBits | Parallel code from the encoder |
| dx_o | output | 1 | Serial transmit data |
| dx_en_o | output | 1 | Output enable for the 3-state data pin |
| ts_n_o | output | 1 | Transmit slot strobe, active low |
| rx_code_o | output | SlotBits | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_code_o updates |

## Verification
Three cases are hard to reach from the ports. The first is a mode change, because the mode decided by one sync pulse only shows in the timing of the following frame. The stimulus therefore runs a wide sync pulse and checks that its own slot keeps short timing, then checks long timing in the next frame. After a power-down it checks that short timing has come back. The second case is a sync that arrives in the middle of a slot. The stimulus raises the sync at bit 4 while the parallel code changes. The current word must still go out intact, and the following frame must carry the code loaded before the intrusion. The third case is a long sync that outlasts the eighth bit, which checks that the enable is held until the sync falls.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    FRM_SHORT = 1'b0,
    FRM_LONG  = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned Width     = 4,
  parameter int unsigned EdgeWidth = 3,
  parameter int unsigned Stages    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [Width-1:0]     async_i,
  output logic [Width-1:0]     lvl_o,
  output logic [EdgeWidth-1:0] rise_o,
  output logic [EdgeWidth-1:0] fall_o
);
  logic [Width-1:0]     stg_q [Stages];
  logic [EdgeWidth-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Stages; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < Stages; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[Stages-1][EdgeWidth-1:0];
    end
  end

  assign lvl_o  = stg_q[Stages-1];
  assign rise_o = lvl_o[EdgeWidth-1:0] & ~prev_q;
  assign fall_o = ~lvl_o[EdgeWidth-1:0] & prev_q;
endmodule

// File: rtl/pcm_frame_mode.sv
module pcm_frame_mode
  import pcm_port_pkg::*;
#(
  parameter int unsigned LongMin = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pdn_i,
  input  logic        fsx_lvl_i,
  input  logic        fsx_fall_i,
  input  logic        bclk_fall_i,
  output frame_mode_e mode_o
);
  localparam int unsigned CntW = $clog2(LongMin + 1);
  localparam logic [CntW-1:0] CntSat = CntW'(LongMin);

  logic [CntW-1:0] wid_q;
  frame_mode_e     mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q  <= '0;
      mode_q <= FRM_SHORT;
    end else if (pdn_i) begin
      wid_q  <= '0;
      mode_q <= FRM_SHORT;
    end else if (fsx_fall_i) begin
      mode_q <= (wid_q >= CntSat) ? FRM_LONG : FRM_SHORT;
      wid_q  <= '0;
    end else if (bclk_fall_i && fsx_lvl_i && wid_q != CntSat) begin
      wid_q <= wid_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

  a_r3_mode_at_sync_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $past(fsx_fall_i || pdn_i));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_port_pkg::*;
#(
  parameter int unsigned Bits = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pdn_i,
  input  frame_mode_e     mode_i,
  input  logic            bclk_lvl_i,
  input  logic            bclk_rise_i,
  input  logic            bclk_fall_i,
  input  logic            fsx_lvl_i,
  input  logic            fsx_rise_i,
  input  logic [Bits-1:0] code_i,
  output logic            dout_o,
  output logic            oe_o
);
  localparam int unsigned CntW = $clog2(Bits + 1);
  localparam logic [CntW-1:0] FullCnt = CntW'(Bits);

  typedef enum logic [2:0] {TX_IDLE, TX_WFALL, TX_WRISE, TX_SHIFT, TX_TAIL} tx_st_e;

  tx_st_e          st_q;
  logic [CntW-1:0] cnt_q;
  logic [Bits-1:0] shreg_q, hold_q;
  logic            primed_q, drive_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= TX_IDLE; cnt_q <= '0; shreg_q <= '0; hold_q <= '0;
      primed_q <= 1'b0; drive_q <= 1'b0; oe_q <= 1'b0;
    end else if (pdn_i) begin
      st_q <= TX_IDLE; cnt_q <= '0; shreg_q <= '0; hold_q <= '0;
      primed_q <= 1'b0; drive_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (fsx_rise_i) begin
          hold_q   <= code_i;
          shreg_q  <= hold_q;
          primed_q <= 1'b1;
          drive_q  <= primed_q;
          if (mode_i == FRM_LONG && bclk_lvl_i) begin
            st_q  <= TX_SHIFT;
            oe_q  <= primed_q;
            cnt_q <= CntW'(1);
          end else if (mode_i == FRM_LONG) begin
            st_q <= TX_WRISE;
          end else begin
            st_q <= TX_WFALL;
          end
        end
        TX_WFALL: if (bclk_fall_i) st_q <= fsx_lvl_i ? TX_WRISE : TX_IDLE;
        TX_WRISE: if (bclk_rise_i) begin
          st_q  <= TX_SHIFT;
          oe_q  <= drive_q;
          cnt_q <= CntW'(1);
        end
        TX_SHIFT: begin
          if (bclk_rise_i && cnt_q != FullCnt) begin
            shreg_q <= {shreg_q[Bits-2:0], 1'b0};
            cnt_q   <= cnt_q + 1'b1;
          end else if (bclk_fall_i && cnt_q == FullCnt) begin
            // long frame: stay on while sync is still high
            if (mode_i == FRM_SHORT || !fsx_lvl_i) begin
              st_q <= TX_IDLE;
              oe_q <= 1'b0;
            end else begin
              st_q <= TX_TAIL;
            end
          end
        end
        TX_TAIL: if (!fsx_lvl_i) begin
          st_q <= TX_IDLE;
          oe_q <= 1'b0;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign dout_o = shreg_q[Bits-1];
  assign oe_o   = oe_q;

  a_r1_pdn_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> !oe_q);
  a_r4_enable_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(bclk_rise_i || fsx_rise_i));
  a_r5_disable_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> $past(bclk_fall_i || pdn_i || !fsx_lvl_i));
  a_r11_busy_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsx_rise_i && st_q != TX_IDLE && !pdn_i) |=> $stable(hold_q));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_port_pkg::*;
#(
  parameter int unsigned Bits = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pdn_i,
  input  frame_mode_e     mode_i,
  input  logic            bclk_fall_i,
  input  logic            fsr_lvl_i,
  input  logic            fsr_rise_i,
  input  logic            fsr_fall_i,
  input  logic            din_i,
  output logic [Bits-1:0] word_o,
  output logic            valid_o
);
  localparam int unsigned CntW = $clog2(Bits + 1);
  localparam logic [CntW-1:0] LastIdx = CntW'(Bits - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_PEND, RX_RECV} rx_st_e;

  rx_st_e          st_q;
  logic [CntW-1:0] cnt_q;
  logic [Bits-1:0] shreg_q, word_q;
  logic            valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE; cnt_q <= '0; shreg_q <= '0; word_q <= '0; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (pdn_i) begin
        st_q  <= RX_IDLE;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          RX_IDLE: if (fsr_rise_i) begin
            cnt_q <= '0;
            st_q  <= (mode_i == FRM_LONG) ? RX_RECV : RX_PEND;
          end
          RX_PEND: begin
            if (bclk_fall_i)     st_q <= fsr_lvl_i ? RX_RECV : RX_IDLE;
            else if (fsr_fall_i) st_q <= RX_IDLE;
          end
          RX_RECV: if (bclk_fall_i) begin
            shreg_q <= {shreg_q[Bits-2:0], din_i};
            if (cnt_q == LastIdx) begin
              word_q  <= {shreg_q[Bits-2:0], din_i};
              valid_q <= 1'b1;
              cnt_q   <= '0;
              st_q    <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  a_r10_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r10_valid_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(bclk_fall_i));
  a_r10_word_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_q) |-> valid_q);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned SlotBits       = 8,
  parameter int unsigned SyncStages     = 2,
  parameter int unsigned LongMinPeriods = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwr_dn_i,
  input  logic                bclk_i,
  input  logic                fs_tx_i,
  input  logic                fs_rx_i,
  input  logic                dr_i,
  input  logic [SlotBits-1:0] tx_code_i,
  output logic                dx_o,
  output logic                dx_en_o,
  output logic                ts_n_o,
  output logic [SlotBits-1:0] rx_code_o,
  output logic                rx_valid_o
);
  localparam int unsigned NumIn   = 4;
  localparam int unsigned NumEdge = 3;
  localparam int unsigned IdxBclk = 0;
  localparam int unsigned IdxFsx  = 1;
  localparam int unsigned IdxFsr  = 2;
  localparam int unsigned IdxDr   = 3;

  logic [NumIn-1:0]   in_lvl;
  logic [NumEdge-1:0] in_rise, in_fall;
  frame_mode_e        mode;

  pcm_edge_sync #(.Width(NumIn), .EdgeWidth(NumEdge), .Stages(SyncStages)) i_sync (
    .clk_i, .rst_ni,
    .async_i ({dr_i, fs_rx_i, fs_tx_i, bclk_i}),
    .lvl_o   (in_lvl),
    .rise_o  (in_rise),
    .fall_o  (in_fall)
  );

  pcm_frame_mode #(.LongMin(LongMinPeriods)) i_mode (
    .clk_i, .rst_ni,
    .pdn_i       (pwr_dn_i),
    .fsx_lvl_i   (in_lvl[IdxFsx]),
    .fsx_fall_i  (in_fall[IdxFsx]),
    .bclk_fall_i (in_fall[IdxBclk]),
    .mode_o      (mode)
  );

  pcm_tx #(.Bits(SlotBits)) i_tx (
    .clk_i, .rst_ni,
    .pdn_i       (pwr_dn_i),
    .mode_i      (mode),
    .bclk_lvl_i  (in_lvl[IdxBclk]),
    .bclk_rise_i (in_rise[IdxBclk]),
    .bclk_fall_i (in_fall[IdxBclk]),
    .fsx_lvl_i   (in_lvl[IdxFsx]),
    .fsx_rise_i  (in_rise[IdxFsx]),
    .code_i      (tx_code_i),
    .dout_o      (dx_o),
    .oe_o        (dx_en_o)
  );

  pcm_rx #(.Bits(SlotBits)) i_rx (
    .clk_i, .rst_ni,
    .pdn_i       (pwr_dn_i),
    .mode_i      (mode),
    .bclk_fall_i (in_fall[IdxBclk]),
    .fsr_lvl_i   (in_lvl[IdxFsr]),
    .fsr_rise_i  (in_rise[IdxFsr]),
    .fsr_fall_i  (in_fall[IdxFsr]),
    .din_i       (in_lvl[IdxDr]),
    .word_o      (rx_code_o),
    .valid_o     (rx_valid_o)
  );

  assign ts_n_o = ~dx_en_o;
endmodule

// File: tb/test_pcm_slot_port.sv
`timescale 1ns/1ps
module test_pcm_slot_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_dn_i = 1'b1;
  logic       bclk_i = 1'b0;
  logic       fs_tx_i = 1'b0;
  logic       fs_rx_i = 1'b0;
  logic       dr_i = 1'b0;
  logic [7:0] tx_code_i = 8'h00;
  logic       dx_o, dx_en_o, ts_n_o, rx_valid_o;
  logic [7:0] rx_code_o;

  int  n_chk = 0, n_bad = 0, vcount = 0;
  bit  finished = 1'b0;
  logic s_en [16];
  logic s_dx [16];
  logic s_ts [16];

  always #2 clk_i = ~clk_i;

  pcm_slot_port i_pcm_slot_port (
    .clk_i, .rst_ni, .pwr_dn_i, .bclk_i, .fs_tx_i, .fs_rx_i, .dr_i, .tx_code_i,
    .dx_o, .dx_en_o, .ts_n_o, .rx_code_o, .rx_valid_o
  );

  always @(posedge clk_i) if (rx_valid_o) vcount <= vcount + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one frame: bclk period 16 clocks, inputs changed 1 clock after the bclk rise
  task automatic run_frame(input int fsx_len, input int fsr_len, input int extra_at,
                           input logic [7:0] start_code, input logic [7:0] mid_code,
                           input logic [7:0] dr_word, input int dr_ofs, input int n_per);
    tx_code_i = start_code;
    for (int p = 0; p < n_per; p++) begin
      @(negedge clk_i); bclk_i = 1'b1;
      @(negedge clk_i);
      fs_tx_i = (p < fsx_len) || (p == extra_at);
      fs_rx_i = (p < fsr_len);
      if (p == 2) tx_code_i = mid_code;
      dr_i = (p >= dr_ofs && p < dr_ofs + 8) ? dr_word[7 - (p - dr_ofs)] : 1'b0;
      repeat (6) @(negedge clk_i);
      s_en[p] = dx_en_o; s_dx[p] = dx_o; s_ts[p] = ts_n_o;
      @(negedge clk_i); bclk_i = 1'b0;
      repeat (7) @(negedge clk_i);
    end
  endtask

  task automatic check_tx(input string req, input int on_first, input int on_last,
                          input logic [7:0] code, input int n_per);
    for (int p = 0; p < n_per; p++) begin
      logic exp_en;
      int   idx;
      exp_en = (p >= on_first) && (p <= on_last);
      idx = p - on_first;
      if (idx > 7) idx = 7;
      chk(s_en[p] == exp_en, req, $sformatf("enable period %0d", p), s_en[p], exp_en);
      chk(s_ts[p] == !exp_en, "R7", $sformatf("strobe period %0d", p), s_ts[p], !exp_en);
      if (exp_en)
        chk(s_dx[p] == code[7 - idx], req, $sformatf("data period %0d", p), s_dx[p], code[7 - idx]);
    end
  endtask

  task automatic check_rx(input string req, input logic [7:0] word, input int v0, input int delta);
    repeat (4) @(negedge clk_i);
    chk(vcount - v0 == delta, req, "valid pulses", vcount - v0, delta);
    if (delta != 0) chk(rx_code_o == word, req, "received word", rx_code_o, word);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    chk(dx_en_o == 1'b0 && ts_n_o == 1'b1 && rx_valid_o == 1'b0, "R1", "in reset",
        {dx_en_o, ts_n_o, rx_valid_o}, 3'b010);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(dx_en_o == 1'b0 && ts_n_o == 1'b1, "R1", "power-down after reset", {dx_en_o, ts_n_o}, 2'b01);
    pwr_dn_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic test_first_sync_gated();
    int v0 = vcount;
    run_frame(1, 1, -1, 8'hA5, 8'hA5, 8'h96, 1, 11);
    check_tx("R2", 1, 0, 8'h00, 11);
    check_rx("R8 R10", 8'h96, v0, 1);
  endtask

  task automatic test_short_tx();
    int v0 = vcount;
    run_frame(1, 0, -1, 8'h3C, 8'h3C, 8'h00, 0, 11);
    check_tx("R4 R6", 1, 8, 8'hA5, 11);
    check_rx("R8 idle", 8'h00, v0, 0);
  endtask

  task automatic test_busy_sync();
    run_frame(1, 0, 4, 8'h5A, 8'hFF, 8'h00, 0, 11);
    check_tx("R11", 1, 8, 8'h3C, 11);
    run_frame(1, 0, -1, 8'h11, 8'h11, 8'h00, 0, 11);
    check_tx("R11 R6", 1, 8, 8'h5A, 11);
  endtask

  task automatic test_long();
    int v0;
    run_frame(4, 0, -1, 8'hC3, 8'hC3, 8'h00, 0, 11);
    check_tx("R3 next-frame", 1, 8, 8'h11, 11);
    v0 = vcount;
    run_frame(4, 4, -1, 8'h0F, 8'h0F, 8'h4B, 0, 11);
    check_tx("R5", 0, 7, 8'hC3, 11);
    check_rx("R9 R10", 8'h4B, v0, 1);
    run_frame(10, 0, -1, 8'h77, 8'h77, 8'h00, 0, 12);
    check_tx("R5 extended", 0, 9, 8'h0F, 12);
  endtask

  task automatic test_power_cycle();
    pwr_dn_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(dx_en_o == 1'b0 && ts_n_o == 1'b1, "R1", "power-down", {dx_en_o, ts_n_o}, 2'b01);
    pwr_dn_i = 1'b0;
    repeat (4) @(negedge clk_i);
    run_frame(1, 0, -1, 8'h99, 8'h99, 8'h00, 0, 11);
    check_tx("R2 repower", 1, 0, 8'h00, 11);
    run_frame(1, 0, -1, 8'h00, 8'h00, 8'h00, 0, 11);
    check_tx("R3 short after power-down", 1, 8, 8'h99, 11);
  endtask

  task automatic test_two_period_sync();
    run_frame(2, 0, -1, 8'h6D, 8'h6D, 8'h00, 0, 11);
    check_tx("R3 two-period", 1, 8, 8'h00, 11);
    run_frame(1, 0, -1, 8'hE1, 8'hE1, 8'h00, 0, 11);
    check_tx("R3 stays short", 1, 8, 8'h6D, 11);
  endtask

  initial begin
    test_reset();
    test_first_sync_gated();
    test_short_tx();
    test_busy_sync();
    test_long();
    test_power_cycle();
    test_two_period_sync();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule